// File: doc/BRIEF.md
# DRAM Refresh and Initialization Sequencer

This block makes sure an asynchronous DRAM is woken up correctly and then kept refreshed for as long as the chip runs. After a synchronous reset it waits out the power-up pause. It then issues a burst of wake-up refresh cycles. From that point on it schedules one CAS-before-RAS refresh per interval, so that every row is refreshed within the retention period. Because the device's own row counter supplies the refresh address, the block drives no address at all. It drives only the two strobes and the write-enable, and holds the write-enable high.

The DRAM pins are shared with an access controller. When at least one refresh is owed, the block raises a request and waits for a grant. It then drives the pins for one or more complete refresh cycles, and releases request and pin ownership together in the same cycle. If the grant is withheld, owed refreshes accumulate up to a small cap and are then issued back to back under one request. An init-done flag tells the host side when the wake-up burst has finished; host accesses must be held off until it is high. The clock period, pause length, retention period and all strobe timings are parameters, so a low-power device with a longer retention period needs only a different parameter value.

Top module: `rfsh_top`

## Requirements
- R1: After reset is released, the block stays silent for PAUSE_CYC = ceil(PAUSE_US / clock period) cycles: req_o and drive_o are 0, ras_n_o and cas_n_o are 1, and init_done_o is 0. req_o first rises on the clock edge PAUSE_CYC+1 after release (12500+1 with defaults at 8 ns).
- R2: After the pause, exactly INIT_CYCLES (8) refresh cycles are issued before init_done_o rises. init_done_o rises on the edge that ends the last of them, and it stays high until reset.
- R3: The block does not drive the pins until it has sampled gnt_i high while requesting. drive_o rises on the edge after that sample. req_o stays high while drive_o is high, and both fall on the same edge after the last owed cycle. gnt_i is expected to stay high while req_o is high.
- R4: Each refresh cycle is CAS-before-RAS with RAS held high at the start. First there are RPC_CYC (2) driven cycles with both strobes high. Then CAS is low for CSR_CYC (2) cycles with RAS still high. Then both strobes are low for ACT_CYC (8) cycles, and both rise together.
- R5: After RAS rises, both strobes stay high for PRE_CYC cycles, where PRE_CYC = max(ceil(tRP), ceil(tRC) − ACT − RPC − CSR), which is 5 at the defaults. Consecutive RAS falls within one grant are therefore 17 cycles apart at the defaults.
- R6: we_n_o is 1 whenever drive_o is 1. While drive_o is 0, ras_n_o and cas_n_o read 1.
- R7: Once init_done_o is high, one refresh becomes owed every REFI_CYC = floor(RETENTION_MS / ROWS / clock period) cycles, which is 1953 at the defaults. The first request after init_done_o rises appears REFI_CYC+1 edges later.
- R8: While the grant is withheld, owed refreshes accumulate up to MAX_PENDING (4), and any further ones are dropped. When the grant arrives, exactly that many cycles are issued back to back under one request.
- R9: With RETENTION_MS = 128, the interval becomes 15625 cycles at 8 ns. The first request after init_done_o rises then appears 15626 edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gnt_i | input | 1 | Pin grant from the access controller |
| req_o | output | 1 | Request for the shared DRAM pins |
| drive_o | output | 1 | Block owns and drives the strobe pins |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, held high during refresh |
| init_done_o | output | 1 | Wake-up burst finished; host traffic allowed |

## Verification
Phase state and outputs are decoded from the same register, so a wrong phase or phase counter shows on the strobes or on drive_o in the very next cycle. A per-clock reference model catches that at once. A fault in the backlog counter is slower to show. It appears as a missing or extra request, or as a wrong number of RAS pulses in a granted burst, one interval or one burst later. An off-by-one in the interval ticker moves the first post-init request by one cycle, and the exact interval count from init_done_o rising pins that down.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    typedef enum logic [2:0] {
        PH_PAUSE = 3'd0,
        PH_IDLE  = 3'd1,
        PH_REQ   = 3'd2,
        PH_SETUP = 3'd3,
        PH_CSR   = 3'd4,
        PH_ACT   = 3'd5,
        PH_PRE   = 3'd6
    } phase_e;

    typedef struct packed {
        logic req;
        logic drive;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } pins_s;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // nanoseconds to whole clock cycles, rounded up, at least one
    function automatic int ns_to_cyc(input longint ns, input int clk_ps);
        longint c;
        c = (ns * 1000 + longint'(clk_ps) - 1) / longint'(clk_ps);
        return (c < 1) ? 1 : int'(c);
    endfunction

    // per-row refresh spacing in cycles, rounded down
    function automatic int interval_cyc(input int ret_ms, input int rows, input int clk_ps);
        longint c;
        c = (longint'(ret_ms) * 64'd1_000_000_000) / (longint'(rows) * longint'(clk_ps));
        return (c < 2) ? 2 : int'(c);
    endfunction

    function automatic pins_s phase_pins(input phase_e ph);
        pins_s p;
        p.req   = (ph != PH_PAUSE) && (ph != PH_IDLE);
        p.drive = (ph == PH_SETUP) || (ph == PH_CSR) || (ph == PH_ACT) || (ph == PH_PRE);
        p.ras_n = (ph != PH_ACT);
        p.cas_n = (ph != PH_CSR) && (ph != PH_ACT);
        p.we_n  = 1'b1;
        return p;
    endfunction

endpackage

// File: rtl/rfsh_ticker.sv
module rfsh_ticker #(
    parameter int PERIOD = 1953
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int TW = $clog2(PERIOD + 1);

    logic [TW-1:0] cnt;
    logic          wrap;

    assign wrap = (cnt == TW'(PERIOD - 1));
    assign tick = en && wrap;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
        end else if (wrap) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rfsh_backlog.sv
module rfsh_backlog #(
    parameter int INIT_CYCLES = 8,
    parameter int MAX_PENDING = 4,
    parameter int OW          = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          tick,
    input  logic          done,
    output logic [OW-1:0] owed
);
    always_ff @(posedge clk) begin
        if (rst) begin
            owed <= '0;
        end else if (load) begin
            owed <= OW'(INIT_CYCLES);
        end else if (tick && !done) begin
            if (owed < OW'(MAX_PENDING)) begin
                owed <= owed + 1'b1;
            end
        end else if (done && !tick) begin
            owed <= owed - 1'b1;
        end
    end
endmodule

// File: rtl/rfsh_seq.sv
module rfsh_seq
    import rfsh_pkg::*;
#(
    parameter int PAUSE_CYC = 12500,
    parameter int RPC_CYC   = 2,
    parameter int CSR_CYC   = 2,
    parameter int ACT_CYC   = 8,
    parameter int PRE_CYC   = 5,
    parameter int OW        = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          gnt,
    input  logic          tick,
    input  logic [OW-1:0] owed,
    output phase_e        phase,
    output logic          load,
    output logic          done,
    output logic          init_done
);
    localparam int PCW = $clog2(PAUSE_CYC + 1);
    localparam int PW  = $clog2(imax(imax(RPC_CYC, CSR_CYC), imax(ACT_CYC, PRE_CYC)) + 1);

    logic [PCW-1:0] pcnt;
    logic [PW-1:0]  cnt;
    logic           more;

    assign load = (phase == PH_PAUSE) && (pcnt == PCW'(PAUSE_CYC - 1));
    assign done = (phase == PH_PRE) && (cnt == PW'(PRE_CYC - 1));
    assign more = (owed > OW'(1)) || tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_PAUSE;
            pcnt      <= '0;
            cnt       <= '0;
            init_done <= 1'b0;
        end else begin
            case (phase)
                PH_PAUSE: begin
                    if (load) phase <= PH_IDLE;
                    else      pcnt  <= pcnt + 1'b1;
                end
                PH_IDLE: begin
                    if (owed != '0) phase <= PH_REQ;
                end
                PH_REQ: begin
                    if (gnt) begin
                        phase <= PH_SETUP;
                        cnt   <= '0;
                    end
                end
                PH_SETUP: begin
                    if (cnt == PW'(RPC_CYC - 1)) begin
                        phase <= PH_CSR;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_CSR: begin
                    if (cnt == PW'(CSR_CYC - 1)) begin
                        phase <= PH_ACT;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_ACT: begin
                    if (cnt == PW'(ACT_CYC - 1)) begin
                        phase <= PH_PRE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_PRE: begin
                    if (done) begin
                        phase <= more ? PH_SETUP : PH_IDLE;
                        cnt   <= '0;
                        if (!init_done && owed == OW'(1)) init_done <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rfsh_top.sv
module rfsh_top
    import rfsh_pkg::*;
#(
    parameter int CLK_PS       = 8000,
    parameter int PAUSE_US     = 100,
    parameter int INIT_CYCLES  = 8,
    parameter int ROWS         = 1024,
    parameter int RETENTION_MS = 16,
    parameter int MAX_PENDING  = 4,
    parameter int T_RAS_NS     = 60,
    parameter int T_RP_NS      = 40,
    parameter int T_RC_NS      = 110,
    parameter int T_CSR_NS     = 10,
    parameter int T_CHR_NS     = 10,
    parameter int T_RPC_NS     = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic gnt_i,
    output logic req_o,
    output logic drive_o,
    output logic ras_n_o,
    output logic cas_n_o,
    output logic we_n_o,
    output logic init_done_o
);
    localparam int PAUSE_CYC = ns_to_cyc(longint'(PAUSE_US) * 1000, CLK_PS);
    localparam int REFI_CYC  = interval_cyc(RETENTION_MS, ROWS, CLK_PS);
    localparam int RPC_CYC   = ns_to_cyc(T_RPC_NS, CLK_PS);
    localparam int CSR_CYC   = ns_to_cyc(T_CSR_NS, CLK_PS);
    localparam int ACT_CYC   = imax(ns_to_cyc(T_RAS_NS, CLK_PS), ns_to_cyc(T_CHR_NS, CLK_PS));
    localparam int RC_REST   = ns_to_cyc(T_RC_NS, CLK_PS) - ACT_CYC - RPC_CYC - CSR_CYC;
    localparam int PRE_CYC   = imax(ns_to_cyc(T_RP_NS, CLK_PS), RC_REST);
    localparam int OW        = $clog2(imax(INIT_CYCLES, MAX_PENDING) + 1);

    phase_e        phase;
    pins_s         pins;
    logic          tick;
    logic          load;
    logic          done;
    logic [OW-1:0] owed;

    rfsh_ticker #(.PERIOD(REFI_CYC)) u_ticker (
        .clk  (clk),
        .rst  (rst),
        .en   (init_done_o),
        .tick (tick)
    );

    rfsh_backlog #(
        .INIT_CYCLES (INIT_CYCLES),
        .MAX_PENDING (MAX_PENDING),
        .OW          (OW)
    ) u_backlog (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .tick (tick),
        .done (done),
        .owed (owed)
    );

    rfsh_seq #(
        .PAUSE_CYC (PAUSE_CYC),
        .RPC_CYC   (RPC_CYC),
        .CSR_CYC   (CSR_CYC),
        .ACT_CYC   (ACT_CYC),
        .PRE_CYC   (PRE_CYC),
        .OW        (OW)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .gnt       (gnt_i),
        .tick      (tick),
        .owed      (owed),
        .phase     (phase),
        .load      (load),
        .done      (done),
        .init_done (init_done_o)
    );

    assign pins    = phase_pins(phase);
    assign req_o   = pins.req;
    assign drive_o = pins.drive;
    assign ras_n_o = pins.ras_n;
    assign cas_n_o = pins.cas_n;
    assign we_n_o  = pins.we_n;
endmodule

// File: rtl/rfsh_chk.sv
module rfsh_chk #(
    parameter int PAUSE_CYC = 12500,
    parameter int ACT_CYC   = 8
) (
    input logic clk,
    input logic rst,
    input logic gnt_i,
    input logic req_o,
    input logic drive_o,
    input logic ras_n_o,
    input logic cas_n_o,
    input logic init_done_o
);
    int since_rst;
    int ras_low;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= 0;
            ras_low   <= 0;
        end else begin
            if (since_rst < PAUSE_CYC) since_rst <= since_rst + 1;
            ras_low <= ras_n_o ? 0 : ras_low + 1;
        end
    end

    // R1
    pause_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst < PAUSE_CYC) |-> (!req_o && !drive_o));

    // R2
    init_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        init_done_o |=> init_done_o);

    // R3
    grant_first_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(drive_o) |-> $past(gnt_i));

    // R3
    drive_in_req_chk: assert property (@(posedge clk) disable iff (rst)
        drive_o |-> req_o);

    // R4
    cas_first_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n_o) |-> $past(!cas_n_o));

    // R4
    cas_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ras_n_o |-> !cas_n_o);

    // R4
    ras_width_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ras_n_o) |-> (ras_low >= ACT_CYC));

    // R6
    idle_pins_chk: assert property (@(posedge clk) disable iff (rst)
        !drive_o |-> (ras_n_o && cas_n_o));
endmodule

bind rfsh_top rfsh_chk #(
    .PAUSE_CYC (PAUSE_CYC),
    .ACT_CYC   (ACT_CYC)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .gnt_i       (gnt_i),
    .req_o       (req_o),
    .drive_o     (drive_o),
    .ras_n_o     (ras_n_o),
    .cas_n_o     (cas_n_o),
    .init_done_o (init_done_o)
);

// File: tb/tb_rfsh_top.sv
module tb_rfsh_top;
    // expected timing at 8 ns, worked out from the requirements
    localparam int PAUSE   = 12500;
    localparam int RPC     = 2;
    localparam int CSR     = 2;
    localparam int ACT     = 8;
    localparam int PRE     = 5;
    localparam int REFI    = 1953;
    localparam int REFI_LP = 15625;
    localparam int INIT    = 8;
    localparam int MAXP    = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic gnt = 1'b0;
    logic gnt_lp = 1'b0;
    logic block = 1'b0;
    logic req, drive, ras_n, cas_n, we_n, init_done;
    logic req_lp, drive_lp, ras_n_lp, cas_n_lp, we_n_lp, init_done_lp;

    always #4 clk = ~clk;

    rfsh_top dut (
        .clk(clk), .rst(rst), .gnt_i(gnt), .req_o(req), .drive_o(drive),
        .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n), .init_done_o(init_done)
    );

    rfsh_top #(.RETENTION_MS(128)) dut_lp (
        .clk(clk), .rst(rst), .gnt_i(gnt_lp), .req_o(req_lp), .drive_o(drive_lp),
        .ras_n_o(ras_n_lp), .cas_n_o(cas_n_lp), .we_n_o(we_n_lp), .init_done_o(init_done_lp)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit lp_done = 1'b0;

    task automatic check(input bit ok, input string rq, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // behavioural reference: 0 pause, 1 idle, 2 request, 3 setup, 4 cas-first, 5 ras-low, 6 precharge
    int m_st, m_pc, m_c, m_owed, m_tc;
    bit m_init;

    function automatic int phase_len(input int st);
        case (st)
            3: return RPC;
            4: return CSR;
            5: return ACT;
            default: return PRE;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_pc = 0; m_c = 0; m_owed = 0; m_tc = 0; m_init = 0;
            cyc = 0;
        end else begin
            bit tk, dn, ld, n_init;
            int n_owed, n_st, n_c;
            cyc++;
            tk = m_init && (m_tc == REFI - 1);
            dn = (m_st == 6) && (m_c == PRE - 1);
            ld = (m_st == 0) && (m_pc == PAUSE - 1);
            n_owed = m_owed;
            if (ld) n_owed = INIT;
            else if (tk && !dn) n_owed = (m_owed < MAXP) ? m_owed + 1 : m_owed;
            else if (dn && !tk) n_owed = m_owed - 1;
            n_init = m_init || (dn && m_owed == 1);
            n_st = m_st;
            n_c = m_c;
            if (m_st == 0) begin
                if (ld) n_st = 1; else m_pc++;
            end else if (m_st == 1) begin
                if (m_owed > 0) n_st = 2;
            end else if (m_st == 2) begin
                if (gnt) begin n_st = 3; n_c = 0; end
            end else if (m_c == phase_len(m_st) - 1) begin
                n_c = 0;
                if (m_st < 6) n_st = m_st + 1;
                else n_st = (m_owed > 1 || tk) ? 3 : 1;
            end else begin
                n_c = m_c + 1;
            end
            m_tc = m_init ? (tk ? 0 : m_tc + 1) : 0;
            m_owed = n_owed; m_st = n_st; m_c = n_c; m_init = n_init;
        end
    end

    // pin-level measurements and per-clock comparison
    int cas_run = 0, ras_lo = 0, falls = 0, init_falls = 0, last_fall = 0;
    bit prev_ras = 1'b1, chain = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            check(req == (m_st >= 2), "R3 req", req, m_st >= 2);
            check(drive == (m_st >= 3), "R3 drive", drive, m_st >= 3);
            check(ras_n == (m_st != 5), "R4 ras_n", ras_n, m_st != 5);
            check(cas_n == !(m_st == 4 || m_st == 5), "R4 cas_n", cas_n, !(m_st == 4 || m_st == 5));
            check(we_n == 1'b1, "R6 we_n", we_n, 1);
            check(init_done == m_init, "R2 init_done", init_done, m_init);
            if (prev_ras && !ras_n) begin
                check(cas_run == CSR, "R4 cas lead", cas_run, CSR);
                if (chain) check(cyc - last_fall == ACT + PRE + RPC + CSR, "R5 ras period",
                                 cyc - last_fall, ACT + PRE + RPC + CSR);
                last_fall = cyc;
                chain = 1'b1;
                falls++;
                if (!init_done) init_falls++;
            end
            if (!prev_ras && ras_n) check(ras_lo == ACT, "R4 ras width", ras_lo, ACT);
            if (!drive) chain = 1'b0;
            cas_run = cas_n ? 0 : cas_run + 1;
            ras_lo = ras_n ? 0 : ras_lo + 1;
            prev_ras = ras_n;
        end
        gnt = req && !block;
        gnt_lp = req_lp;
    end

    // low-power variant: interval from init_done to first request
    initial begin
        int t;
        wait (!rst);
        do step(); while (!init_done_lp);
        t = cyc;
        do step(); while (!req_lp);
        check(cyc - t == REFI_LP + 1, "R9 long interval", cyc - t, REFI_LP + 1);
        lp_done = 1'b1;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int t, f0;
        repeat (4) step();
        // R1 reset state
        check(!req && !drive && ras_n && cas_n && !init_done, "R1 reset outputs",
              {req, drive, ras_n, cas_n, init_done}, 5'b00110);
        @(negedge clk);
        rst = 1'b0;
        do step(); while (!req);
        check(cyc == PAUSE + 1, "R1 pause length", cyc, PAUSE + 1);
        do step(); while (!init_done);
        check(init_falls == INIT, "R2 wake-up count", init_falls, INIT);
        t = cyc;
        do step(); while (!req);
        check(cyc - t == REFI + 1, "R7 interval", cyc - t, REFI + 1);
        do step(); while (req);
        block = 1'b1;
        repeat (6 * REFI) step();
        check(req && !drive, "R3 wait for grant", {req, drive}, 2'b10);
        f0 = falls;
        block = 1'b0;
        do step(); while (req);
        check(falls - f0 == MAXP, "R8 backlog burst", falls - f0, MAXP);
        wait (lp_done);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule